// File: doc/BRIEF.md
# Switch-Sequenced 2x2 Matrix Multiplier

This block holds two 2x2 matrices, A and B, whose entries are written one at a time through a small register-write port. It also holds an expected result matrix written through the same port. Four board switches control it. Two load switches open A and B for writing. A multiply switch starts a clocked, element-by-element product into a result matrix Z. A show switch routes Z to four time-multiplexed seven-segment digits.

Every switch passes through a two-flop synchronizer and a counter debouncer before any logic sees it. The multiply computes one element of Z per clock, so Z takes four cycles. A fifth cycle compares Z with the expected matrix. After that the block raises a done flag, and it lights a status LED when the result matches.

Top module: `mat2_switch_mult`

## Requirements
- R1: Entry k of each matrix holds row i = k/2 and column j = k%2. Z[i][j] = A[i][0]*B[0][j] + A[i][1]*B[1][j]. Entries of A and B are 1 or 2, and each Z element is 4 bits wide.
- R2: A write has effect when wr_en is high. wr_tgt selects the matrix: 0 = A, 1 = B, 2 = expected, 3 = none. wr_idx is the entry index k. A and B take wr_data[1:0], and the expected matrix takes wr_data[3:0]. A write to A is ignored unless the debounced load-A switch is high, and the same holds for B with load-B.
- R3: A multiply starts on a debounced rising edge of the multiply switch, and only when both debounced load switches are low. Otherwise the edge starts nothing.
- R4: A multiply spends four cycles computing elements, one per cycle, then one cycle checking the result. done rises only after this busy interval, never in the cycle the start is seen.
- R5: Starting a multiply clears done and the status LED until the new result is ready.
- R6: The status LED is high only while done is high, and only if every Z element equals the expected matrix entry when the check cycle runs.
- R7: A switch level that lasts fewer than DEB_CYCLES clocks after synchronization has no effect.
- R8: While the debounced show switch is high, exactly one bit of an_n is low at any time. That bit advances every REFRESH_CYCLES clocks, and an_n[k] low means seg_n shows Z entry k. While show is low, all of an_n and seg_n are high.
- R9: seg_n[6:0] holds segments g..a, active low (bit 0 = a). The values 0 to 8 give the patterns 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000 and 0000000. dp_n is always high.
- R10: After reset, done and led_ok are low and all of an_n and seg_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_tgt | input | 2 | Write target: 0 A, 1 B, 2 expected, 3 none |
| wr_idx | input | 2 | Entry index k = 2*row + column |
| wr_data | input | 4 | Entry value |
| sw_load_a | input | 1 | Raw switch that opens A for writing |
| sw_load_b | input | 1 | Raw switch that opens B for writing |
| sw_mult | input | 1 | Raw switch that starts a multiply on its rise |
| sw_show | input | 1 | Raw switch that enables the display |
| seg_n | output | 7 | Segments g..a, active low |
| dp_n | output | 1 | Decimal point, active low, held off |
| an_n | output | 4 | Digit anodes, active low |
| led_ok | output | 1 | Result matches the expected matrix |
| done | output | 1 | Multiply finished |

## Verification
Z can only be observed through the scanned display. The bench therefore holds the show switch and samples every cycle across several full refresh rotations, and it checks each active digit against its own computed product. The hardest cases to reach are the rejected ones: a write to A with its load switch low, a multiply edge while a load switch is high, and a short glitch on the multiply switch. Each of these is driven on purpose. Where a write was ignored, the bench proves it with a later multiply, whose displayed result and LED would differ if the write had landed.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int DIM = 2;
  localparam int NEL = DIM * DIM;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_CHECK = 2'd2
  } core_st_e;

  localparam logic [1:0] TGT_A   = 2'd0;
  localparam logic [1:0] TGT_B   = 2'd1;
  localparam logic [1:0] TGT_EXP = 2'd2;

  // active-low segment pattern, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] seg7_lo(input logic [3:0] v);
    logic [6:0] on;
    case (v)
      4'd0: on = 7'h3F;
      4'd1: on = 7'h06;
      4'd2: on = 7'h5B;
      4'd3: on = 7'h4F;
      4'd4: on = 7'h66;
      4'd5: on = 7'h6D;
      4'd6: on = 7'h7D;
      4'd7: on = 7'h07;
      4'd8: on = 7'h7F;
      default: on = 7'h00;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/sw_debounce.sv
module sw_debounce #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic       sync1_q, sync2_q;
  logic       level_q, level_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    level_d = level_q;
    cnt_d   = '0;
    if (sync2_q != level_q) begin
      if (cnt_q == CW'(DEB_CYCLES - 1)) begin
        level_d = sync2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level = level_q;
endmodule

// File: rtl/mm_core.sv
module mm_core
  import mm_pkg::*;
#(
  parameter int EW = 2,
  parameter int ZW = 2 * EW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_tgt,
  input  logic [1:0]          wr_idx,
  input  logic [ZW-1:0]       wr_data,
  input  logic                load_a,
  input  logic                load_b,
  input  logic                start,
  output logic [NEL*ZW-1:0]   z_flat,
  output logic                busy,
  output logic                done,
  output logic                ok
);
  localparam int IW = $clog2(NEL);

  logic [EW-1:0] a_q [NEL];
  logic [EW-1:0] b_q [NEL];
  logic [ZW-1:0] e_q [NEL];
  logic [ZW-1:0] z_q [NEL];

  core_st_e      st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d, ok_q, ok_d;
  logic [ZW-1:0] elem;
  logic          match;
  logic [IW-1:0] ia0, ia1, ib0, ib1;

  // operand indices for the element being produced this cycle
  assign ia0 = {idx_q[1], 1'b0};
  assign ia1 = {idx_q[1], 1'b1};
  assign ib0 = {1'b0, idx_q[0]};
  assign ib1 = {1'b1, idx_q[0]};
  assign elem = ZW'(a_q[ia0]) * ZW'(b_q[ib0]) + ZW'(a_q[ia1]) * ZW'(b_q[ib1]);

  always_comb begin
    match = 1'b1;
    for (int k = 0; k < NEL; k++) begin
      if (z_q[k] != e_q[k]) match = 1'b0;
    end
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    done_d = done_q;
    ok_d   = ok_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_RUN;
          idx_d  = '0;
          done_d = 1'b0;
          ok_d   = 1'b0;
        end
      end
      ST_RUN: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IW'(NEL - 1)) st_d = ST_CHECK;
      end
      ST_CHECK: begin
        done_d = 1'b1;
        ok_d   = match;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  for (genvar k = 0; k < NEL; k++) begin : g_ent
    logic wa, wb, we, wz;
    assign wa = wr_en && (wr_tgt == TGT_A) && load_a && (wr_idx == IW'(k));
    assign wb = wr_en && (wr_tgt == TGT_B) && load_b && (wr_idx == IW'(k));
    assign we = wr_en && (wr_tgt == TGT_EXP) && (wr_idx == IW'(k));
    assign wz = (st_q == ST_RUN) && (idx_q == IW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q[k] <= '0;
        b_q[k] <= '0;
        e_q[k] <= '0;
        z_q[k] <= '0;
      end else begin
        if (wa) a_q[k] <= wr_data[EW-1:0];
        if (wb) b_q[k] <= wr_data[EW-1:0];
        if (we) e_q[k] <= wr_data;
        if (wz) z_q[k] <= elem;
      end
    end

    assign z_flat[k*ZW +: ZW] = z_q[k];
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign ok   = ok_q;
endmodule

// File: rtl/seg_scan.sv
module seg_scan
  import mm_pkg::*;
#(
  parameter int REFRESH_CYCLES = 8,
  parameter int ZW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              show,
  input  logic [NEL*ZW-1:0] z_flat,
  output logic [NEL-1:0]    an_n,
  output logic [6:0]        seg_n
);
  localparam int CW = $clog2(REFRESH_CYCLES);
  localparam int DW = $clog2(NEL);

  logic [CW-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]  dig_q, dig_d;
  logic [NEL-1:0] an_q, an_d;
  logic [6:0]     seg_q, seg_d;
  logic [ZW-1:0]  val;
  logic           tick;

  assign val  = z_flat[dig_q*ZW +: ZW];
  assign tick = (cnt_q == CW'(REFRESH_CYCLES - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    dig_d = tick ? dig_q + 1'b1 : dig_q;
    if (show) begin
      an_d  = ~(NEL'(1) << dig_q);
      seg_d = seg7_lo(4'(val));
    end else begin
      an_d  = '1;
      seg_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dig_q <= '0;
      an_q  <= '1;
      seg_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      dig_q <= dig_d;
      an_q  <= an_d;
      seg_q <= seg_d;
    end
  end

  assign an_n  = an_q;
  assign seg_n = seg_q;
endmodule

// File: rtl/mat2_switch_mult.sv
module mat2_switch_mult
  import mm_pkg::*;
#(
  parameter int EW             = 2,
  parameter int DEB_CYCLES     = 16,
  parameter int REFRESH_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_tgt,
  input  logic [1:0] wr_idx,
  input  logic [3:0] wr_data,
  input  logic       sw_load_a,
  input  logic       sw_load_b,
  input  logic       sw_mult,
  input  logic       sw_show,
  output logic [6:0] seg_n,
  output logic       dp_n,
  output logic [3:0] an_n,
  output logic       led_ok,
  output logic       done
);
  localparam int ZW  = 2 * EW;
  localparam int NSW = 4;

  logic [NSW-1:0]    sw_raw, sw_db;
  logic              mult_prev_q;
  logic              start_w, busy_w, ok_w;
  logic [NEL*ZW-1:0] z_flat;

  // 0 load A, 1 load B, 2 multiply, 3 show
  assign sw_raw = {sw_show, sw_mult, sw_load_b, sw_load_a};

  for (genvar s = 0; s < NSW; s++) begin : g_sw
    sw_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (sw_raw[s]),
      .level (sw_db[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mult_prev_q <= 1'b0;
    else        mult_prev_q <= sw_db[2];
  end

  assign start_w = sw_db[2] && !mult_prev_q && !sw_db[0] && !sw_db[1];

  mm_core #(.EW(EW), .ZW(ZW)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_tgt  (wr_tgt),
    .wr_idx  (wr_idx),
    .wr_data (ZW'(wr_data)),
    .load_a  (sw_db[0]),
    .load_b  (sw_db[1]),
    .start   (start_w),
    .z_flat  (z_flat),
    .busy    (busy_w),
    .done    (done),
    .ok      (ok_w)
  );

  seg_scan #(.REFRESH_CYCLES(REFRESH_CYCLES), .ZW(ZW)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .show   (sw_db[3]),
    .z_flat (z_flat),
    .an_n   (an_n),
    .seg_n  (seg_n)
  );

  assign led_ok = ok_w;
  assign dp_n   = 1'b1;
endmodule

// File: rtl/mm_checker.sv
module mm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       led,
  input logic       load_a,
  input logic       load_b,
  input logic [3:0] an_n,
  input logic [6:0] seg_n
);
  assert_start_loads_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!load_a && !load_b));

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy, 1) && $past(busy, 5)));

  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!done && !led));

  assert_led_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    led |-> done);

  assert_one_anode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~an_n));

  assert_blank_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&an_n) |-> (&seg_n));
endmodule

bind mat2_switch_mult mm_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start_w),
  .busy   (busy_w),
  .done   (done),
  .led    (led_ok),
  .load_a (sw_db[0]),
  .load_b (sw_db[1]),
  .an_n   (an_n),
  .seg_n  (seg_n)
);

// File: tb/sim_mat2_switch_mult.sv
`timescale 1ns/1ps
module sim_mat2_switch_mult;
  localparam int DEB     = 16;
  localparam int REFRESH = 8;
  localparam int SETTLE  = DEB + 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_tgt = 2'd3;
  logic [1:0] wr_idx = 2'd0;
  logic [3:0] wr_data = 4'd0;
  logic       sw_load_a = 1'b0, sw_load_b = 1'b0, sw_mult = 1'b0, sw_show = 1'b0;
  logic [6:0] seg_n;
  logic       dp_n;
  logic [3:0] an_n;
  logic       led_ok, done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench copy of the matrices, entry k = 2*row + col
  int ma [4];
  int mb [4];
  int mz [4];

  always #2.5 clk = ~clk;

  mat2_switch_mult #(.EW(2), .DEB_CYCLES(DEB), .REFRESH_CYCLES(REFRESH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_idx(wr_idx),
    .wr_data(wr_data), .sw_load_a(sw_load_a), .sw_load_b(sw_load_b),
    .sw_mult(sw_mult), .sw_show(sw_show), .seg_n(seg_n), .dp_n(dp_n),
    .an_n(an_n), .led_ok(led_ok), .done(done)
  );

  function automatic logic [6:0] exp_seg(input int v);
    case (v)
      0: return 7'b1000000;
      1: return 7'b1111001;
      2: return 7'b0100100;
      3: return 7'b0110000;
      4: return 7'b0011001;
      5: return 7'b0010010;
      6: return 7'b0000010;
      7: return 7'b1111000;
      8: return 7'b0000000;
      default: return 7'b1111111;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic compute_z();
    for (int k = 0; k < 4; k++) begin
      int i = k / 2;
      int j = k % 2;
      mz[k] = ma[2*i] * mb[j] + ma[2*i+1] * mb[2+j];
    end
  endtask

  task automatic wr(input logic [1:0] tgt, input int idx, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_tgt = tgt; wr_idx = 2'(idx); wr_data = 4'(val);
    @(negedge clk);
    wr_en = 1'b0; wr_tgt = 2'd3;
  endtask

  task automatic load_a(input int v0, input int v1, input int v2, input int v3);
    sw_load_a = 1'b1; cyc(SETTLE);
    wr(2'd0, 0, v0); wr(2'd0, 1, v1); wr(2'd0, 2, v2); wr(2'd0, 3, v3);
    ma[0] = v0; ma[1] = v1; ma[2] = v2; ma[3] = v3;
    sw_load_a = 1'b0; cyc(SETTLE);
  endtask

  task automatic load_b(input int v0, input int v1, input int v2, input int v3);
    sw_load_b = 1'b1; cyc(SETTLE);
    wr(2'd1, 0, v0); wr(2'd1, 1, v1); wr(2'd1, 2, v2); wr(2'd1, 3, v3);
    mb[0] = v0; mb[1] = v1; mb[2] = v2; mb[3] = v3;
    sw_load_b = 1'b0; cyc(SETTLE);
  endtask

  task automatic load_exp(input int v0, input int v1, input int v2, input int v3);
    wr(2'd2, 0, v0); wr(2'd2, 1, v1); wr(2'd2, 2, v2); wr(2'd2, 3, v3);
  endtask

  task automatic t_reset();
    cyc(1);
    check("R10 done", done, 0);
    check("R10 led", led_ok, 0);
    check("R10 an_n", an_n, 4'hF);
    check("R10 seg_n", seg_n, 7'h7F);
    check("R9 dp_n", dp_n, 1);
  endtask

  // multiply: R4 done low mid-run, R5 cleared, R6 led outcome
  task automatic t_run(input logic exp_led, input string tag);
    sw_mult = 1'b1;
    cyc(DEB + 5);
    check({"R5 done cleared during run ", tag}, done, 0);
    check({"R5 led cleared during run ", tag}, led_ok, 0);
    cyc(20);
    check({"R4 done after run ", tag}, done, 1);
    check({"R6 led ", tag}, led_ok, exp_led);
    sw_mult = 1'b0; cyc(SETTLE);
  endtask

  task automatic t_display(input string tag);
    bit seen [4];
    for (int k = 0; k < 4; k++) seen[k] = 0;
    sw_show = 1'b1; cyc(SETTLE);
    for (int c = 0; c < 8 * REFRESH; c++) begin
      int lows = 0;
      int dig = -1;
      @(negedge clk);
      for (int k = 0; k < 4; k++) if (!an_n[k]) begin lows++; dig = k; end
      check({"R8 one anode ", tag}, lows, 1);
      if (dig >= 0) begin
        seen[dig] = 1;
        check({"R1 R9 digit value ", tag}, seg_n, exp_seg(mz[dig]));
      end
      check("R9 dp off", dp_n, 1);
    end
    for (int k = 0; k < 4; k++) check({"R8 digit rotated ", tag}, seen[k], 1);
    sw_show = 1'b0; cyc(SETTLE);
    check("R8 blank when off an", an_n, 4'hF);
    check("R8 blank when off seg", seg_n, 7'h7F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();

    // R2: load, then try writing A with its switch low (must be ignored)
    load_a(1, 2, 2, 1);
    load_b(2, 1, 1, 2);
    wr(2'd0, 0, 2);
    wr(2'd1, 3, 1);
    compute_z();
    load_exp(mz[0], mz[1], mz[2], mz[3]);

    // R3: edge with load switch high starts nothing
    sw_load_a = 1'b1; cyc(SETTLE);
    sw_mult = 1'b1; cyc(SETTLE + 10);
    check("R3 no start with load high", done, 0);
    sw_mult = 1'b0; cyc(SETTLE);
    sw_load_a = 1'b0; cyc(SETTLE);

    // R7: short glitch on the multiply switch
    sw_mult = 1'b1; cyc(3); sw_mult = 1'b0;
    cyc(SETTLE + 10);
    check("R7 glitch ignored", done, 0);

    // R1/R2/R6: run with correct expectation; ignored writes keep LED on
    t_run(1'b1, "first");
    t_display("first");

    // new matrices, stale expectation: LED must stay off (R5, R6)
    load_a(2, 2, 2, 2);
    load_b(2, 2, 2, 2);
    compute_z();
    t_run(1'b0, "mismatch");
    t_display("all8");

    // matching expectation again
    load_exp(8, 8, 8, 8);
    t_run(1'b1, "match8");

    // mixed pattern
    load_a(2, 1, 1, 1);
    load_b(1, 2, 2, 1);
    compute_z();
    load_exp(mz[0], mz[1], mz[2], mz[3]);
    t_run(1'b1, "mixed");
    t_display("mixed");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule